// File: doc/BRIEF.md
# Command-Driven SPI Master Engine

This block is the serial core of an SPI master. Software, or a sequencer in front of it, writes a 32-bit command word that sets everything one transfer needs: clock polarity and phase, frame length, which of four chip-select lines to drive, the SCK rate and how chip select behaves when a frame ends. The engine then takes data words from a transmit FIFO, shifts each one out most-significant bit first on MOSI while it captures MISO, and writes each received word to a receive FIFO. The bus is full duplex, so every transmitted frame yields exactly one received frame.

Chip select can span several command-delimited transfers, so that together they form one message on the bus. A hold bit keeps the line asserted after each frame. A separate chain bit on the next command says whether that command joins the open assertion or starts a fresh one. A command with the chain bit clear releases any line that is still held.

The control FSM has four states. ST_IDLE accepts commands and starts frames. ST_LEAD asserts chip select and waits one SCK half-period. ST_SHIFT produces the 2N clock edges of an N-bit frame. ST_TRAIL waits one more half-period, pushes the received word and releases chip select unless it is held.

The FSM has five transitions:
- IDLE→LEAD when a frame starts.
- LEAD→SHIFT on the first divider tick.
- SHIFT→TRAIL on the last edge of the frame.
- TRAIL→IDLE on the next tick.
- IDLE→IDLE when a command is accepted, since a command takes priority over starting a frame.

Top module: `spi_cmd_master`

## Requirements
- R1: `cmd_ready` is high only in the idle state, and it is high out of reset. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and no frame starts on that cycle. The command fields are:
  - bit 31: SCK polarity.
  - bit 30: phase.
  - bits 29:27: prescaler select p.
  - bits 25:24: chip-select index.
  - bit 21: hold.
  - bit 20: chain.
  - bits 4:0: frame length minus one.
- R2: A frame is N = field+1 bits long, for N from 8 to 32. A length field below 7 is treated as 7, which gives 8 bits. The received word is returned right-aligned, with the bits above N at zero.
- R3: MOSI carries the transmit word's low N bits, most-significant bit first. With phase 0, a bit is presented before the leading SCK edge and MISO is sampled on leading edges. With phase 1, bits are launched on leading edges and MISO is sampled on trailing edges.
- R4: SCK rests at the polarity level while no frame is being shifted, and it toggles only while a chip select is active. Each SCK half-period lasts 2^p clock cycles.
- R5: During a frame, only the chip-select line chosen by the index is active. At no time is more than one line active.
- R6: With `cs_active_high` at 0, chip-select lines are active low, so all outputs are 1 when idle. With it at 1, they are active high.
- R7: With hold clear, chip select is released after every frame, and each frame gets its own assertion.
- R8: With hold set, chip select stays active after the frame. A following command with the chain bit set keeps that assertion with no new rising event. A command with the chain bit clear releases the line as soon as it is accepted.
- R9: Each frame pops one transmit word and, unless the receive FIFO is full at the frame's end, pushes one received word. Pop and push never share a cycle.
- R10: With `no_stall` at 0, no frame starts while `rx_full` is high. With `no_stall` at 1, the frame runs and its received word is dropped.
- R11: `xfer_done` is 0 after reset and is cleared when a frame starts. It is set when a frame ends with the transmit FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_active_high | input | 1 | Chip-select polarity: 0 active low, 1 active high |
| no_stall | input | 1 | 1: run frames even when the receive FIFO is full |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Per-transfer command word |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Take the head word from the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_data | output | 32 | Received word, right-aligned |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| xfer_done | output | 1 | Transfer complete flag |

## Verification
The four SCK modes are each run against a bus-slave model, using different frame lengths (8, 12, 16 and 32 bits) and different prescalers. A phase or polarity mistake therefore shows up as shifted or inverted bits, not as a coincidental match. The transmit and slave words change every frame, so a stuck or reused shift register is caught.

Chip-select sequences count rising events on the active line:
- Independent frames, to show the release after each frame.
- Held frames followed by a chained command, to show one assertion.
- A non-chained command, to show the immediate release.

A full receive FIFO is tried in both stall modes, which tells waiting apart from dropping.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int CMD_W    = 32;
    localparam int SIZE_W   = 5;
    localparam int PRE_W    = 3;
    localparam int IDX_W    = 2;
    localparam int MIN_M1   = 7;

    typedef struct packed {
        logic               cpol;
        logic               cpha;
        logic [PRE_W-1:0]   presc;
        logic [IDX_W-1:0]   cs_idx;
        logic               hold_cs;
        logic               chain;
        logic [SIZE_W-1:0]  size_m1;
    } spi_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } spi_state_e;

    // Field positions are fixed by the command format.
    function automatic spi_cfg_t decode_cmd(input logic [CMD_W-1:0] w);
        spi_cfg_t c;
        c.cpol    = w[31];
        c.cpha    = w[30];
        c.presc   = w[29:27];
        c.cs_idx  = w[25:24];
        c.hold_cs = w[21];
        c.chain   = w[20];
        c.size_m1 = (w[4:0] < SIZE_W'(MIN_M1)) ? SIZE_W'(MIN_M1) : w[4:0];
        return c;
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
// Half-period tick generator: one tick every 2^presc cycles while run is high.
module spi_clk_div #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);
    localparam int CNT_W = 1 << PRE_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim  = (CNT_W'(1) << presc) - CNT_W'(1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_frame_shifter.sv
// Full-duplex frame shifter, MSB first, variable length.
module spi_frame_shifter #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [SIZE_W-1:0] size_m1,
    input  logic              cpha,
    input  logic              edge_en,
    input  logic              miso,
    output logic              mosi,
    output logic              phase,
    output logic [DATA_W-1:0] rx_word,
    output logic              last_edge
);
    localparam int EC_W = SIZE_W + 2;
    localparam logic [SIZE_W-1:0] TOP_BIT = SIZE_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr_q;
    logic [DATA_W-1:0] rx_sr_q;
    logic [EC_W-1:0]   edge_cnt_q;
    logic              mosi_q;
    logic              phase_q;
    logic [DATA_W-1:0] aligned;
    logic              sample_now;

    // Left-align so the frame MSB sits at the shifter's top bit.
    assign aligned    = tx_word << (TOP_BIT - size_m1);
    // Edge k (counted from 0): phase 0 samples on even k, phase 1 on odd k.
    assign sample_now = (edge_cnt_q[0] == cpha);
    // The last edge of an N-bit frame has index 2N-1.
    assign last_edge  = edge_en && (edge_cnt_q == {1'b0, size_m1, 1'b1});

    assign mosi    = mosi_q;
    assign phase   = phase_q;
    assign rx_word = rx_sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr_q    <= '0;
            rx_sr_q    <= '0;
            edge_cnt_q <= '0;
            mosi_q     <= 1'b0;
            phase_q    <= 1'b0;
        end else if (load) begin
            edge_cnt_q <= '0;
            phase_q    <= 1'b0;
            rx_sr_q    <= '0;
            mosi_q     <= aligned[DATA_W-1];
            if (cpha) begin
                tx_sr_q <= aligned;
            end else begin
                tx_sr_q <= aligned << 1;
            end
        end else if (edge_en) begin
            edge_cnt_q <= edge_cnt_q + EC_W'(1);
            phase_q    <= ~phase_q;
            if (sample_now) begin
                rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso};
            end else begin
                mosi_q  <= tx_sr_q[DATA_W-1];
                tx_sr_q <= tx_sr_q << 1;
            end
        end
    end
endmodule

// File: rtl/spi_cs_drive.sv
// Chip-select decoder with selectable polarity.
module spi_cs_drive #(
    parameter int CS_N  = 4,
    parameter int IDX_W = 2
) (
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    input  logic             act_high,
    output logic [CS_N-1:0]  cs_o
);
    for (genvar i = 0; i < CS_N; i++) begin : g_line
        logic sel;
        assign sel     = active && (idx == IDX_W'(i));
        assign cs_o[i] = act_high ? sel : ~sel;
    end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CS_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active_high,
    input  logic              no_stall,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_ready,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_N-1:0]   cs_o,
    output logic              xfer_done
);
    spi_state_e state_q, state_d;
    spi_cfg_t   cfg_q, cmd_dec;
    logic       cfg_vld_q;
    logic       cs_on_q;
    logic [IDX_W-1:0] cs_idx_q;
    logic       done_q;

    logic       cmd_take;
    logic       start_ok;
    logic       tick;
    logic       edge_en;
    logic       last_edge;
    logic       phase;
    logic       div_run;

    assign cmd_dec  = decode_cmd(cmd_word);
    assign start_ok = cfg_vld_q && !tx_empty && (no_stall || !rx_full);
    assign div_run  = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cmd_valid && start_ok) state_d = ST_LEAD;
            ST_LEAD:  if (tick)                   state_d = ST_SHIFT;
            ST_SHIFT: if (last_edge)              state_d = ST_TRAIL;
            ST_TRAIL: if (tick)                   state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        cmd_ready = 1'b0;
        cmd_take  = 1'b0;
        tx_pop    = 1'b0;
        edge_en   = 1'b0;
        rx_push   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                cmd_take  = cmd_valid;
                tx_pop    = !cmd_valid && start_ok;
            end
            ST_LEAD:  ;
            ST_SHIFT: edge_en = tick;
            ST_TRAIL: rx_push = tick && !rx_full;
            default:  ;
        endcase
    end

    // Configuration, chip-select and completion bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_vld_q <= 1'b0;
            cs_on_q   <= 1'b0;
            cs_idx_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            if (cmd_take) begin
                cfg_q     <= cmd_dec;
                cfg_vld_q <= 1'b1;
                if (!cmd_dec.chain) begin
                    cs_on_q  <= 1'b0;
                    cs_idx_q <= cmd_dec.cs_idx;
                end else if (!cs_on_q) begin
                    cs_idx_q <= cmd_dec.cs_idx;
                end
            end
            if (tx_pop) begin
                cs_on_q <= 1'b1;
                done_q  <= 1'b0;
            end
            if (state_q == ST_TRAIL && tick) begin
                if (!cfg_q.hold_cs) begin
                    cs_on_q <= 1'b0;
                end
                done_q <= tx_empty;
            end
        end
    end

    spi_clk_div #(
        .PRE_W (PRE_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .presc (cfg_q.presc),
        .tick  (tick)
    );

    spi_frame_shifter #(
        .DATA_W (DATA_W),
        .SIZE_W (SIZE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_pop),
        .tx_word   (tx_data),
        .size_m1   (cfg_q.size_m1),
        .cpha      (cfg_q.cpha),
        .edge_en   (edge_en),
        .miso      (miso),
        .mosi      (mosi),
        .phase     (phase),
        .rx_word   (rx_data),
        .last_edge (last_edge)
    );

    spi_cs_drive #(
        .CS_N  (CS_N),
        .IDX_W (IDX_W)
    ) u_cs (
        .active   (cs_on_q),
        .idx      (cs_idx_q),
        .act_high (cs_active_high),
        .cs_o     (cs_o)
    );

    assign sck       = cfg_q.cpol ^ phase;
    assign xfer_done = done_q;

endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
    parameter int CS_N = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_active_high,
    input logic            no_stall,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            tx_empty,
    input logic            tx_pop,
    input logic            rx_full,
    input logic            rx_push,
    input logic            sck,
    input logic [CS_N-1:0] cs_o,
    input logic            xfer_done
);
    logic [CS_N-1:0] cs_act;
    assign cs_act = cs_active_high ? cs_o : ~cs_o;

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act));

    // R4
    sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sck != $past(sck)) && !$past(cmd_valid && cmd_ready)) |-> (|cs_act));

    // R1
    cmd_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |-> !tx_pop);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !no_stall) |-> !tx_pop);

    // R9
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !tx_pop);

    // R11
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(tx_empty));

endmodule

bind spi_cmd_master spi_cmd_master_chk #(.CS_N(CS_N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_active_high (cs_active_high),
    .no_stall       (no_stall),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .tx_empty       (tx_empty),
    .tx_pop         (tx_pop),
    .rx_full        (rx_full),
    .rx_push        (rx_push),
    .sck            (sck),
    .cs_o           (cs_o),
    .xfer_done      (xfer_done)
);

// File: tb/tb_spi_cmd_master.sv
`timescale 1ns/1ps
module tb_spi_cmd_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_active_high = 1'b0;
    logic        no_stall = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ready;
    logic        tx_empty;
    logic [31:0] tx_data;
    logic        tx_pop;
    logic        rx_full = 1'b0;
    logic [31:0] rx_data;
    logic        rx_push;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_o;
    logic        xfer_done;

    always #2.5 clk = ~clk;

    spi_cmd_master dut (
        .clk(clk), .rst_n(rst_n), .cs_active_high(cs_active_high), .no_stall(no_stall),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_data(rx_data), .rx_push(rx_push),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o), .xfer_done(xfer_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int cyc = 0;

    // Transmit and receive FIFO models
    logic [31:0] tx_mem [16];
    int          tx_wr = 0;
    int          tx_rd = 0;
    logic [31:0] rx_mem [64];
    int          rx_wr = 0;
    assign tx_empty = (tx_rd == tx_wr);
    assign tx_data  = tx_mem[tx_rd % 16];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_pop) tx_rd <= tx_rd + 1;
        if (rx_push) begin
            rx_mem[rx_wr % 64] <= rx_data;
            rx_wr <= rx_wr + 1;
        end
    end

    // Bus slave model and monitor
    int          m_n = 8;
    bit          m_cpol = 0;
    bit          m_cpha = 0;
    logic [31:0] s_word [64];
    int          s_rd = 0;
    int          m_k = 0;
    logic [31:0] m_bits = '0;
    logic [31:0] cap [64];
    int          cap_cnt = 0;
    logic        prev_sck = 1'b0;
    int          last_edge_cyc = 0;
    int          half_meas = 0;
    int          cs_rise = 0;
    logic [3:0]  prev_act = 4'h0;
    logic [3:0]  cs_snap = 4'h0;
    logic [3:0]  cs_act;
    assign cs_act = cs_active_high ? cs_o : ~cs_o;

    function automatic logic [31:0] nmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (|(cs_act & ~prev_act)) cs_rise = cs_rise + 1;
            prev_act = cs_act;
            if ((sck !== prev_sck) && (|cs_act)) begin
                half_meas     = cyc - last_edge_cyc;
                last_edge_cyc = cyc;
                if ((sck != m_cpol) ^ m_cpha) begin
                    if (m_k == 0) cs_snap = cs_o;
                    m_bits = {m_bits[30:0], mosi};
                    m_k = m_k + 1;
                    if (m_k == m_n) begin
                        cap[cap_cnt % 64] = m_bits & nmask(m_n);
                        cap_cnt = cap_cnt + 1;
                        m_k = 0;
                        s_rd = s_rd + 1;
                    end
                end
            end
            prev_sck = sck;
            miso = s_word[s_rd % 64][m_n - 1 - m_k];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit cpol, input bit cpha, input int p,
                                           input int idx, input bit hold, input bit chain,
                                           input int m1);
        logic [31:0] w;
        w = '0;
        w[31] = cpol; w[30] = cpha; w[29:27] = 3'(p); w[25:24] = 2'(idx);
        w[21] = hold; w[20] = chain; w[4:0] = 5'(m1);
        return w;
    endfunction

    logic [31:0] exp_tx [16];
    logic [31:0] exp_rx [16];
    int          x_cnt = 0;
    int          x_cap0 = 0;
    int          x_rx0 = 0;
    logic        idle_sck;

    task automatic send_cmd(input logic [31:0] w);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // R2 length rule: fields below 7 give 8 bits
    task automatic start_xfer(input logic [31:0] w, input int cnt, input logic [31:0] seed);
        int m1;
        m1 = (w[4:0] < 5'd7) ? 7 : int'(w[4:0]);
        send_cmd(w);
        idle_sck = sck;
        m_n = m1 + 1; m_cpol = w[31]; m_cpha = w[30];
        x_cnt = cnt; x_cap0 = cap_cnt; x_rx0 = rx_wr;
        for (int i = 0; i < cnt; i++) begin
            exp_tx[i] = seed * 32'(i + 3) ^ 32'hA5C3_3C5A;
            exp_rx[i] = (seed + 32'h1357_9BDF * 32'(i + 1)) & nmask(m_n);
            s_word[(s_rd + i) % 64] = exp_rx[i];
        end
        for (int i = 0; i < cnt; i++) begin
            tx_mem[tx_wr % 16] = exp_tx[i];
            tx_wr = tx_wr + 1;
        end
    endtask

    task automatic finish_xfer(input bit exp_push);
        while (cap_cnt < x_cap0 + x_cnt) @(negedge clk);
        while (!xfer_done) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < x_cnt; i++)
            chk("R3 mosi frame", cap[(x_cap0 + i) % 64], exp_tx[i] & nmask(m_n));
        if (exp_push) begin
            for (int i = 0; i < x_cnt; i++)
                chk("R9 rx word", rx_mem[(x_rx0 + i) % 64], exp_rx[i]);
        end else begin
            chk("R10 dropped words", 32'(rx_wr - x_rx0), 32'd0);
        end
        chk("R11 done set", {31'd0, xfer_done}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R6 reset cs", {28'd0, cs_o}, 32'hF);
        chk("R4 reset sck", {31'd0, sck}, 32'd0);
        chk("R11 reset done", {31'd0, xfer_done}, 32'd0);
        chk("R1 reset ready", {31'd0, cmd_ready}, 32'd1);
    endtask

    task automatic t_mode0_indep;
        int r0;
        r0 = cs_rise;
        start_xfer(mk_cmd(0, 0, 0, 0, 0, 0, 7), 2, 32'h0000_00A5);
        finish_xfer(1);
        chk("R7 assert per frame", 32'(cs_rise - r0), 32'd2);
        chk("R7 released", {28'd0, cs_o}, 32'hF);
        chk("R2 rx upper zero", rx_mem[x_rx0 % 64] & ~nmask(8), 32'd0);
    endtask

    task automatic t_mode3;
        start_xfer(mk_cmd(1, 1, 2, 2, 0, 0, 15), 2, 32'h0BEE_F123);
        chk("R4 idle sck at polarity", {31'd0, idle_sck}, 32'd1);
        finish_xfer(1);
        chk("R4 half period p=2", 32'(half_meas), 32'd4);
        chk("R5 cs line 2", {28'd0, cs_snap}, 32'hB);
        chk("R4 sck rests after", {31'd0, sck}, 32'd1);
    endtask

    task automatic t_mode1_32;
        start_xfer(mk_cmd(0, 1, 1, 1, 0, 0, 31), 3, 32'h8421_7EDC);
        finish_xfer(1);
        chk("R4 half period p=1", 32'(half_meas), 32'd2);
        chk("R5 cs line 1", {28'd0, cs_snap}, 32'hD);
    endtask

    task automatic t_mode2_12;
        start_xfer(mk_cmd(1, 0, 0, 3, 0, 0, 11), 2, 32'h0000_0F39);
        finish_xfer(1);
        chk("R5 cs line 3", {28'd0, cs_snap}, 32'h7);
    endtask

    task automatic t_clamp;
        start_xfer(mk_cmd(0, 0, 0, 0, 0, 0, 3), 1, 32'h0000_1234);
        finish_xfer(1);
        chk("R2 clamped to 8 bits", 32'(m_n), 32'd8);
    endtask

    task automatic t_hold_chain;
        int r0;
        r0 = cs_rise;
        start_xfer(mk_cmd(0, 0, 0, 0, 1, 0, 7), 2, 32'h0000_0033);
        finish_xfer(1);
        chk("R8 held after frames", {28'd0, cs_o}, 32'hE);
        start_xfer(mk_cmd(0, 0, 0, 0, 1, 1, 7), 2, 32'h0000_0077);
        finish_xfer(1);
        chk("R8 single assertion", 32'(cs_rise - r0), 32'd1);
        chk("R8 still held", {28'd0, cs_o}, 32'hE);
        send_cmd(mk_cmd(0, 0, 0, 0, 0, 0, 7));
        chk("R8 unchained cmd releases", {28'd0, cs_o}, 32'hF);
        start_xfer(mk_cmd(0, 0, 0, 0, 0, 0, 7), 1, 32'h0000_0055);
        finish_xfer(1);
        chk("R8 fresh assertion", 32'(cs_rise - r0), 32'd2);
    endtask

    task automatic t_polarity;
        cs_active_high = 1'b1;
        @(negedge clk);
        chk("R6 idle active-high", {28'd0, cs_o}, 32'h0);
        start_xfer(mk_cmd(0, 0, 0, 2, 0, 0, 7), 1, 32'h0000_00C7);
        finish_xfer(1);
        chk("R6 line 2 high", {28'd0, cs_snap}, 32'h4);
        cs_active_high = 1'b0;
    endtask

    task automatic t_stall;
        int c0;
        rx_full = 1'b1; no_stall = 1'b0;
        c0 = cap_cnt;
        start_xfer(mk_cmd(0, 0, 0, 1, 0, 0, 7), 1, 32'h0000_0099);
        repeat (40) @(negedge clk);
        chk("R10 no pop while full", 32'(tx_wr - tx_rd), 32'd1);
        chk("R10 no frame while full", 32'(cap_cnt - c0), 32'd0);
        rx_full = 1'b0;
        finish_xfer(1);
        rx_full = 1'b1; no_stall = 1'b1;
        start_xfer(mk_cmd(0, 1, 0, 1, 0, 0, 7), 1, 32'h0000_0066);
        finish_xfer(0);
        rx_full = 1'b0; no_stall = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) s_word[i] = '0;
        for (int i = 0; i < 16; i++) tx_mem[i] = '0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_mode0_indep();
        t_mode3();
        t_mode1_32();
        t_mode2_12();
        t_clamp();
        t_hold_chain();
        t_polarity();
        t_stall();
        repeat (5) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule